// File: doc/BRIEF.md
# Push-Button Reset Debouncer

This block takes an active-low manual reset input, which may come from a bouncing mechanical switch or from a logic driver, and turns it into a clean reset request. The raw level first passes through a flop synchroniser. A free-running divider then produces a periodic sample tick (one per millisecond in the intended configuration), and a qualifier counts ticks. A press is accepted only when the line has been low for a run of consecutive ticks. Brief low glitches therefore die out, while a sustained press is accepted after a bounded delay.

Once a press is accepted, the request stays up for as long as the button is held. A release counts only after the line has stayed high for its own run of consecutive ticks, so contact chatter on release does not end the request early. A stretcher then holds the reset output active for a fixed number of ticks, measured from the end of the request. The hold time therefore runs from the moment the button lets go, not from the moment the press was recognised. The reset output is active high and is meant to feed the chip's reset distribution.

Top module: `pushbtn_reset_filter`

## Requirements
- R1: After `rst_n` is released with `btn_n_i` high, both `req_o` and `rst_o` are 0 and remain 0 while the input stays high.
- R2: The input is active low. A 0 on `btn_n_i` is a press and a 1 is released. The input passes through `SYNC_STAGES` (default 2) flops before any decision is made.
- R3: A low pulse shorter than one tick period (`TICK_CYCLES` cycles) never raises `req_o` or `rst_o`.
- R4: With `T` = `TICK_CYCLES` and `A` = `ACCEPT_TICKS`, take the last clock edge before `btn_n_i` falls as `t0`. If the input then stays low, `req_o` rises at an edge between `t0+3+(A-1)*T` and `t0+2+A*T` inclusive. With 1 ms ticks and A = 4, this lies between 1 ms and 20 ms.
- R5: Any high sample clears the press count. A train of lows, each shorter than `A-1` tick periods and separated by highs of at least two cycles, never raises `req_o`.
- R6: `req_o` stays 1 while the input is held low. With `Rl` = `RELEASE_TICKS`, take the last edge before the final rise of the input as `t1`. `req_o` then falls at an edge between `t1+3+(Rl-1)*T` and `t1+2+Rl*T` inclusive.
- R7: While a press is accepted, a high interval shorter than `Rl-1` tick periods that is followed by a return to low leaves `req_o` at 1. The release count starts over.
- R8: `rst_o` rises in the same cycle as `req_o` and falls exactly `HOLD_TICKS*TICK_CYCLES` cycles after the edge at which `req_o` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| btn_n_i | input | 1 | Raw manual reset input, active low, asynchronous |
| req_o | output | 1 | Qualified press request, high while the accepted press is held |
| rst_o | output | 1 | Stretched reset output, active high |

## Verification
The main function is driven with five input shapes. A clean long press and a press just long enough to qualify pin down the acceptance and release windows, and the exact hold length. A single sub-tick glitch shows that short pulses are rejected. A train of medium lows broken by short highs separates a counter that clears on any high sample from one that merely accumulates low time. A press with a bounce in the middle of its release shows that release needs a continuous high run. Every output edge is compared with a window computed from the input timestamps, and any edge that no stimulus predicted is reported against the scenario in progress.

// File: rtl/pbf_pkg.sv
package pbf_pkg;

   // Qualifier state: line considered released or pressed
   typedef enum logic {
      PBF_OPEN    = 1'b0,
      PBF_PRESSED = 1'b1
   } pbf_state_t;

   // Bits needed to hold values 0..n
   function automatic int unsigned width_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/pbf_sync.sv
module pbf_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   initial begin
      assert (STAGES >= 2 && STAGES <= 4)
         else $error("pbf_sync: STAGES must be 2..4");
   end

   logic chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RESET_VAL;
            else        chain[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RESET_VAL;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/pbf_tick.sv
module pbf_tick
   import pbf_pkg::*;
#(
   parameter int unsigned CYCLES = 125000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   initial begin
      assert (CYCLES >= 1) else $error("pbf_tick: CYCLES must be >= 1");
   end

   if (CYCLES == 1) begin : g_every
      assign tick_o = 1'b1;
   end else begin : g_div
      localparam int unsigned W    = width_for(CYCLES - 1);
      localparam logic [W-1:0] LAST = W'(CYCLES - 1);

      logic [W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cnt <= '0;
         else if (cnt == LAST) cnt <= '0;
         else                  cnt <= cnt + 1'b1;
      end

      assign tick_o = (cnt == LAST);

      // Ticks are isolated pulses; qualification timing depends on it
      assert_tick_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
         tick_o |=> !tick_o);
   end

endmodule

// File: rtl/pbf_qualify.sv
module pbf_qualify
   import pbf_pkg::*;
#(
   parameter int unsigned ACCEPT_TICKS  = 4,
   parameter int unsigned RELEASE_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic btn_i,     // synchronised level, 1 = released
   output logic req_o
);

   initial begin
      assert (ACCEPT_TICKS >= 1 && RELEASE_TICKS >= 1)
         else $error("pbf_qualify: tick counts must be >= 1");
   end

   localparam int unsigned NMAX = (ACCEPT_TICKS > RELEASE_TICKS) ? ACCEPT_TICKS : RELEASE_TICKS;
   localparam int unsigned W    = width_for(NMAX);
   localparam logic [W-1:0] ACC_LAST = W'(ACCEPT_TICKS - 1);
   localparam logic [W-1:0] REL_LAST = W'(RELEASE_TICKS - 1);

   pbf_state_t   state;
   logic [W-1:0] run_cnt;
   logic         opposing;   // sample disagrees with current state
   logic [W-1:0] run_last;

   always_comb begin
      if (state == PBF_OPEN) begin
         opposing = ~btn_i;
         run_last = ACC_LAST;
      end else begin
         opposing = btn_i;
         run_last = REL_LAST;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= PBF_OPEN;
         run_cnt <= '0;
      end else if (!opposing) begin
         run_cnt <= '0;
      end else if (tick_i) begin
         if (run_cnt == run_last) begin
            state   <= (state == PBF_OPEN) ? PBF_PRESSED : PBF_OPEN;
            run_cnt <= '0;
         end else begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end

   assign req_o = (state == PBF_PRESSED);

   // Acceptance happens only on a tick that saw a low sample
   assert_accept_on_low_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> $past(tick_i && !btn_i));

   // Release happens only on a tick that saw a high sample
   assert_release_on_high_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_o) |-> $past(tick_i && btn_i));

   // A press is never accepted from a high sample (count cleared)
   assert_no_accept_when_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_o && btn_i) |=> !req_o);

endmodule

// File: rtl/pbf_stretch.sv
module pbf_stretch
   import pbf_pkg::*;
#(
   parameter int unsigned HOLD_TICKS = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic req_i,
   output logic rst_o
);

   initial begin
      assert (HOLD_TICKS >= 1) else $error("pbf_stretch: HOLD_TICKS must be >= 1");
   end

   localparam int unsigned W    = width_for(HOLD_TICKS);
   localparam logic [W-1:0] FULL = W'(HOLD_TICKS);

   logic [W-1:0] hold_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          hold_cnt <= '0;
      else if (req_i)                      hold_cnt <= FULL;
      else if (tick_i && hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
   end

   assign rst_o = req_i | (hold_cnt != '0);

   // Reset persists past the end of the request
   assert_hold_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_i) |-> rst_o);

   // Reset ends only on a tick boundary
   assert_drop_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_o) |-> $past(tick_i));

endmodule

// File: rtl/pushbtn_reset_filter.sv
module pushbtn_reset_filter
   import pbf_pkg::*;
#(
   parameter int unsigned TICK_CYCLES   = 125000,
   parameter int unsigned ACCEPT_TICKS  = 4,
   parameter int unsigned RELEASE_TICKS = 4,
   parameter int unsigned HOLD_TICKS    = 250,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_n_i,
   output logic req_o,
   output logic rst_o
);

   logic btn_s;
   logic tick;
   logic req;

   pbf_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (btn_n_i),
      .q_o   (btn_s)
   );

   pbf_tick #(.CYCLES(TICK_CYCLES)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   pbf_qualify #(.ACCEPT_TICKS(ACCEPT_TICKS), .RELEASE_TICKS(RELEASE_TICKS)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .btn_i  (btn_s),
      .req_o  (req)
   );

   pbf_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_stretch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .req_i  (req),
      .rst_o  (rst_o)
   );

   assign req_o = req;

   // Idle input after reset keeps the outputs quiet
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_o && btn_s) |=> !req_o);

endmodule

// File: tb/sim_pushbtn_reset_filter.sv
module sim_pushbtn_reset_filter;

   localparam int T  = 10;
   localparam int NA = 4;
   localparam int NR = 4;
   localparam int NH = 25;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   logic btn_n = 1'b1;
   logic req, rst;

   always #4 clk = ~clk;   // 125 MHz

   pushbtn_reset_filter #(
      .TICK_CYCLES(T), .ACCEPT_TICKS(NA), .RELEASE_TICKS(NR),
      .HOLD_TICKS(NH), .SYNC_STAGES(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .btn_n_i(btn_n), .req_o(req), .rst_o(rst)
   );

   typedef struct {
      bit    rise;
      int    lo;
      int    hi;
      string tag;
   } exp_t;

   exp_t  q_req[$];
   exp_t  q_rst[$];
   int    cyc    = 0;
   int    checks = 0;
   int    errors = 0;
   string idle_tag = "R1";

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   // Monitor: compare each output edge with the queued expectation
   initial begin
      logic pr, ps;
      exp_t e;
      pr = 1'b0; ps = 1'b0;
      forever begin
         @(posedge clk); #1;
         cyc++;
         if (rst_n) begin
            if (req !== pr) begin
               if (q_req.size() == 0) begin
                  check(1'b0, idle_tag, "unexpected req_o edge to", int'(req), int'(pr));
               end else begin
                  e = q_req.pop_front();
                  check(e.rise == req, e.tag, "req_o edge direction", int'(req), int'(e.rise));
                  check(cyc >= e.lo && cyc <= e.hi, e.tag,
                        $sformatf("req_o edge cycle (window %0d..%0d)", e.lo, e.hi), cyc, e.lo);
               end
               if (req === 1'b0)
                  q_rst.push_back('{1'b0, cyc + NH*T, cyc + NH*T, "R8"});
            end
            if (rst !== ps) begin
               if (q_rst.size() == 0) begin
                  check(1'b0, idle_tag, "unexpected rst_o edge to", int'(rst), int'(ps));
               end else begin
                  e = q_rst.pop_front();
                  check(e.rise == rst, e.tag, "rst_o edge direction", int'(rst), int'(e.rise));
                  check(cyc >= e.lo && cyc <= e.hi, e.tag,
                        $sformatf("rst_o edge cycle (window %0d..%0d)", e.lo, e.hi), cyc, e.lo);
               end
            end
         end
         pr = req;
         ps = rst;
      end
   end

   // Driver helpers
   task automatic go_low(input string rise_tag);
      @(negedge clk);
      btn_n = 1'b0;
      q_req.push_back('{1'b1, cyc + 3 + (NA-1)*T, cyc + 2 + NA*T, rise_tag});
      q_rst.push_back('{1'b1, cyc + 3 + (NA-1)*T, cyc + 2 + NA*T, "R8"});
   endtask

   task automatic go_high_final(input string fall_tag);
      @(negedge clk);
      btn_n = 1'b1;
      q_req.push_back('{1'b0, cyc + 3 + (NR-1)*T, cyc + 2 + NR*T, fall_tag});
   endtask

   task automatic settle(input string tag);
      repeat ((NR + 2)*T + NH*T + 4) @(negedge clk);
      check(q_req.size() == 0, tag, "pending req_o expectations", q_req.size(), 0);
      check(q_rst.size() == 0, tag, "pending rst_o expectations", q_rst.size(), 0);
      check(req == 1'b0 && rst == 1'b0, tag, "outputs idle after scenario",
            int'({req, rst}), 0);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", cyc, 0);
      summary();
   end

   initial begin
      // R1: reset state and idle line
      repeat (3) @(negedge clk);
      check(req == 1'b0 && rst == 1'b0, "R1", "outputs during reset", int'({req, rst}), 0);
      rst_n = 1'b1;
      idle_tag = "R1";
      repeat (8*T) @(negedge clk);
      check(req == 1'b0 && rst == 1'b0, "R1", "outputs idle after reset", int'({req, rst}), 0);

      // R2/R4/R6/R8: clean 20-tick press
      idle_tag = "R4";
      go_low("R4");
      repeat (20*T) @(negedge clk);
      check(req == 1'b1 && rst == 1'b1, "R6", "held press keeps outputs", int'({req, rst}), 3);
      go_high_final("R6");
      settle("R8");

      // R4: press just long enough to qualify
      idle_tag = "R4";
      go_low("R4");
      repeat (NA*T + 3) @(negedge clk);
      go_high_final("R6");
      settle("R4");

      // R3: sub-tick glitches
      idle_tag = "R3";
      @(negedge clk); btn_n = 1'b0;
      repeat (T - 1) @(negedge clk);
      btn_n = 1'b1;
      repeat (3*T) @(negedge clk);
      for (int i = 0; i < 6; i++) begin
         btn_n = 1'b0; @(negedge clk);
         btn_n = 1'b1; @(negedge clk);
      end
      repeat (8*T) @(negedge clk);
      check(req == 1'b0 && rst == 1'b0, "R3", "glitches rejected", int'({req, rst}), 0);

      // R5: train of medium lows broken by short highs
      idle_tag = "R5";
      for (int i = 0; i < 5; i++) begin
         btn_n = 1'b0;
         repeat (2*T) @(negedge clk);
         btn_n = 1'b1;
         repeat (2) @(negedge clk);
      end
      repeat (8*T) @(negedge clk);
      check(req == 1'b0 && rst == 1'b0, "R5", "bounce train rejected", int'({req, rst}), 0);

      // R7: bounce during release
      idle_tag = "R4";
      go_low("R4");
      repeat (20*T) @(negedge clk);
      idle_tag = "R7";
      btn_n = 1'b1;
      repeat (2*T) @(negedge clk);
      btn_n = 1'b0;
      repeat (5*T) @(negedge clk);
      check(req == 1'b1, "R7", "req_o kept through release bounce", int'(req), 1);
      go_high_final("R7");
      settle("R7");

      summary();
   end

endmodule